// File: doc/BRIEF.md
# Multi-channel DAC SPI Register Bank

This block is the serial control front end of a multi-channel digital-to-analog converter. A host sends 24-bit command frames over SPI. Each frame carries a two-bit mode, a six-bit address and a 16-bit payload. Mode 3 writes a channel's input code, mode 2 writes its offset trim and mode 1 writes its gain trim. Mode 0 reaches a small special-function space. That space holds a power-down control, a set of group offset registers shared by several channels, and a readback selector.

Readback takes two frames. One frame names a register by a type code and an address. The host then releases chip select and clocks a second frame, during which the block shifts the selected value out on MISO.

The SPI pins are oversampled in the system clock domain. The block drives three outputs: the current code of every channel, the group offsets (both as the raw registers and as the offset seen by each channel), and a global power-down flag. Parameters set the channel count, the channels per group, the number of group offset registers and the code width (14 or 16 bits).

Top module: `dac_spi_regbank`

## Requirements
- R1: A frame is 24 bits sent most significant bit first. MOSI is sampled on rising SCLK edges while CS_n is low. Bits 23:22 are the mode, bits 21:16 the address and bits 15:0 the payload.
- R2: Mode 3 writes the input code of channel c, which sits at address c+8. The channel's code output updates a few system clocks after the 24th bit.
- R3: Mode 2 writes the offset trim and mode 1 writes the gain trim of channel c, also at address c+8. Readback type 2 returns the offset trim and type 3 returns the gain trim.
- R4: With DATA_W = 14, codes and trims are left-justified in the payload. Payload bits 1:0 are ignored on write and read back as zero, and the code output carries payload bits 15:2.
- R5: Mode 0 at address 1 sets the power-down flag from payload bit 0. Readback type 4 at address 1 returns the flag in bit 0, with all other bits zero.
- R6: Mode 0 at addresses 2, 3 and 4 writes group offset registers 0, 1 and 2 from payload bits 13:0. Readback type 4 at those addresses returns the 14-bit value zero-extended.
- R7: Channel c uses group offset register min(c / CH_PER_GRP, NUM_GOFS-1). With the defaults (CH_PER_GRP = 4, NUM_GOFS = 3), channels 0-3 use register 0, channels 4-7 use register 1, and channels 8-15 use register 2.
- R8: A mode-0 frame at address 5 is a readback select. Payload bits 15:13 are the type and bits 12:7 the target address. Types 0 and 1 both return the channel's input code. During the next frame, MISO carries 8 zero bits and then the 16-bit value, MSB first, changing on falling SCLK edges.
- R9: The frame that follows any full frame other than a readback select shifts out all zeros. A select with type 5 to 7, or with an address that names no register, also returns zero.
- R10: A frame in which CS_n rises before 24 bits have been received changes no register and leaves any pending readback in place.
- R11: Bits clocked in after the 24th bit of a frame are ignored.
- R12: After reset, every code, trim, group offset and the power-down flag are zero, and MISO is low.
- R13: A mode 1 to 3 write to an address below 8 or at or beyond 8+NUM_CH changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, which oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | SPI serial clock |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI serial data in |
| miso | output | 1 | SPI serial data out; low while not selected |
| ch_code | output | NUM_CH*DATA_W | Current input code of each channel, channel 0 in the low bits |
| grp_ofs | output | NUM_GOFS*14 | Group offset registers, register 0 in the low bits |
| ch_grp_ofs | output | NUM_CH*14 | Group offset that applies to each channel |
| pwr_dn | output | 1 | Global power-down flag |

## Verification
About 120 random frames exercise every mode. The addresses are drawn both inside and outside the channel range, and the readback selects use random types and targets. Each frame's MISO word is compared with a model, so a wrong mode decode, a wrong address offset or a wrong readback mux shows up either in the outputs or in the returned word.

Directed frames cover the cases that random traffic reaches only rarely:
- all-ones payloads, which show up masking in the 14-bit configuration and in the group offset registers;
- channels on each side of a group boundary and beyond the last group, which separate the group clamp from plain division;
- frames cut short or run long, which separate bit counting from edge counting;
- a no-operation frame placed between a select and its return frame, which shows whether the pending readback is cleared.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

  localparam int FRAME_W  = 24;
  localparam int PAY_W    = 16;
  localparam int GOFS_W   = 14;
  localparam int ADDR_W   = 6;

  // address map
  localparam int CH_BASE  = 8;
  localparam int SF_CTRL  = 1;
  localparam int SF_GOFS0 = 2;
  localparam int SF_RBSEL = 5;

  typedef enum logic [1:0] {
    MODE_SF   = 2'd0,
    MODE_GAIN = 2'd1,
    MODE_OFS  = 2'd2,
    MODE_DATA = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    RB_CODE_A = 3'd0,
    RB_CODE_B = 3'd1,
    RB_OFS    = 3'd2,
    RB_GAIN   = 3'd3,
    RB_SF     = 3'd4
  } rb_e;

  typedef struct packed {
    mode_e             mode;
    logic [ADDR_W-1:0] addr;
    logic [PAY_W-1:0]  pay;
  } frame_t;

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/dac_spi_rx.sv
module dac_spi_rx
  import dac_spi_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk,
  input  logic   cs_n,
  input  logic   mosi,
  output logic   sel,
  output logic   sclk_fall,
  output logic   cs_fall,
  output logic   frame_vld,
  output frame_t frame
);

  localparam int              CNT_W    = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic [2:0]         sclk_q, sclk_d;
  logic [2:0]         csn_q, csn_d;
  logic [1:0]         mosi_q, mosi_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic               vld_q, vld_d;
  frame_t             frm_q, frm_d;
  logic               sclk_rise;

  // pin synchronisers and edge detection
  always_comb begin
    sclk_d = {sclk_q[1:0], sclk};
    csn_d  = {csn_q[1:0], cs_n};
    mosi_d = {mosi_q[0], mosi};
  end

  assign sclk_rise = sclk_q[1] & ~sclk_q[2];
  assign sclk_fall = ~sclk_q[1] & sclk_q[2];
  assign sel       = ~csn_q[1];
  assign cs_fall   = ~csn_q[1] & csn_q[2];

  // bit counter and shift register
  always_comb begin
    cnt_d = cnt_q;
    sh_d  = sh_q;
    vld_d = 1'b0;
    frm_d = frm_q;
    if (!sel) begin
      cnt_d = '0;
    end else if (sclk_rise && (cnt_q < FULL_CNT)) begin
      sh_d  = {sh_q[FRAME_W-2:0], mosi_q[1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST_BIT) begin
        vld_d = 1'b1;
        frm_d = frame_t'(sh_d);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 3'b000;
      csn_q  <= 3'b111;
      mosi_q <= 2'b00;
      cnt_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      frm_q  <= '0;
    end else begin
      sclk_q <= sclk_d;
      csn_q  <= csn_d;
      mosi_q <= mosi_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      vld_q  <= vld_d;
      if (vld_d) frm_q <= frm_d;
    end
  end

  assign frame_vld = vld_q;
  assign frame     = frm_q;

  // a frame is only committed while the slave is selected
  assert_commit_in_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> $past(sel));

  // the bit counter saturates at a full frame; later bits are dropped
  assert_count_saturates_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

endmodule

// File: rtl/dac_spi_tx.sv
module dac_spi_tx
  import dac_spi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             sclk_fall,
  input  logic             cs_fall,
  input  logic [PAY_W-1:0] rd_word,
  output logic             miso
);

  logic [FRAME_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (cs_fall) begin
      sh_d = {{(FRAME_W - PAY_W){1'b0}}, rd_word};
    end else if (sel && sclk_fall) begin
      sh_d = {sh_q[FRAME_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign miso = sel & sh_q[FRAME_W-1];

  // within a frame MISO only moves after a falling SCLK or at frame start
  assert_miso_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sclk_fall && !cs_fall) ##1 sel |-> $stable(miso));

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_spi_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int DATA_W   = 14,
  parameter int NUM_GOFS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_vld,
  input  frame_t                     frame,
  output logic [PAY_W-1:0]           rd_word,
  output logic [NUM_CH*DATA_W-1:0]   ch_code,
  output logic [NUM_GOFS*GOFS_W-1:0] grp_ofs,
  output logic                       pwr_dn
);

  localparam logic [PAY_W-1:0] CODE_MASK = PAY_W'({PAY_W{1'b1}} << (PAY_W - DATA_W));

  logic [PAY_W-1:0]  dat_q [NUM_CH];
  logic [PAY_W-1:0]  dat_d [NUM_CH];
  logic [PAY_W-1:0]  ofs_q [NUM_CH];
  logic [PAY_W-1:0]  ofs_d [NUM_CH];
  logic [PAY_W-1:0]  gn_q  [NUM_CH];
  logic [PAY_W-1:0]  gn_d  [NUM_CH];
  logic [GOFS_W-1:0] gofs_q[NUM_GOFS];
  logic [GOFS_W-1:0] gofs_d[NUM_GOFS];
  logic              pd_q, pd_d;
  logic [PAY_W-1:0]  rd_q, rd_d;
  logic [PAY_W-1:0]  rb_val;
  logic [ADDR_W-1:0] rb_addr;
  logic              is_rbsel;

  assign rb_addr  = frame.pay[12:7];
  assign is_rbsel = (frame.mode == MODE_SF) && (frame.addr == ADDR_W'(SF_RBSEL));

  // readback mux, evaluated against the registers as they stand
  always_comb begin
    rb_val = '0;
    case (rb_e'(frame.pay[15:13]))
      RB_CODE_A, RB_CODE_B: begin
        for (int c = 0; c < NUM_CH; c++)
          if (rb_addr == ADDR_W'(CH_BASE + c)) rb_val = dat_q[c];
      end
      RB_OFS: begin
        for (int c = 0; c < NUM_CH; c++)
          if (rb_addr == ADDR_W'(CH_BASE + c)) rb_val = ofs_q[c];
      end
      RB_GAIN: begin
        for (int c = 0; c < NUM_CH; c++)
          if (rb_addr == ADDR_W'(CH_BASE + c)) rb_val = gn_q[c];
      end
      RB_SF: begin
        if (rb_addr == ADDR_W'(SF_CTRL)) rb_val = {{(PAY_W-1){1'b0}}, pd_q};
        for (int g = 0; g < NUM_GOFS; g++)
          if (rb_addr == ADDR_W'(SF_GOFS0 + g))
            rb_val = {{(PAY_W - GOFS_W){1'b0}}, gofs_q[g]};
      end
      default: rb_val = '0;
    endcase
  end

  // next-state decode of a committed frame
  always_comb begin
    dat_d  = dat_q;
    ofs_d  = ofs_q;
    gn_d   = gn_q;
    gofs_d = gofs_q;
    pd_d   = pd_q;
    rd_d   = rd_q;
    if (frame_vld) begin
      case (frame.mode)
        MODE_DATA: begin
          for (int c = 0; c < NUM_CH; c++)
            if (frame.addr == ADDR_W'(CH_BASE + c)) dat_d[c] = frame.pay & CODE_MASK;
        end
        MODE_OFS: begin
          for (int c = 0; c < NUM_CH; c++)
            if (frame.addr == ADDR_W'(CH_BASE + c)) ofs_d[c] = frame.pay & CODE_MASK;
        end
        MODE_GAIN: begin
          for (int c = 0; c < NUM_CH; c++)
            if (frame.addr == ADDR_W'(CH_BASE + c)) gn_d[c] = frame.pay & CODE_MASK;
        end
        MODE_SF: begin
          if (frame.addr == ADDR_W'(SF_CTRL)) pd_d = frame.pay[0];
          for (int g = 0; g < NUM_GOFS; g++)
            if (frame.addr == ADDR_W'(SF_GOFS0 + g)) gofs_d[g] = frame.pay[GOFS_W-1:0];
        end
      endcase
      rd_d = is_rbsel ? rb_val : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CH; c++) begin
        dat_q[c] <= '0;
        ofs_q[c] <= '0;
        gn_q[c]  <= '0;
      end
      for (int g = 0; g < NUM_GOFS; g++) gofs_q[g] <= '0;
      pd_q <= 1'b0;
      rd_q <= '0;
    end else if (frame_vld) begin
      dat_q  <= dat_d;
      ofs_q  <= ofs_d;
      gn_q   <= gn_d;
      gofs_q <= gofs_d;
      pd_q   <= pd_d;
      rd_q   <= rd_d;
    end
  end

  genvar gc, gg;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_code
      assign ch_code[gc*DATA_W +: DATA_W] = dat_q[gc][PAY_W-1 -: DATA_W];
    end
    for (gg = 0; gg < NUM_GOFS; gg++) begin : g_gofs
      assign grp_ofs[gg*GOFS_W +: GOFS_W] = gofs_q[gg];
    end
  endgenerate

  assign pwr_dn  = pd_q;
  assign rd_word = rd_q;

  // a code write to channel 0 lands masked one clock later
  assert_code_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && frame.mode == MODE_DATA && frame.addr == ADDR_W'(CH_BASE))
    |=> dat_q[0] == ($past(frame.pay) & CODE_MASK));

  // power-down only moves on a committed frame
  assert_pd_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_vld |=> $stable(pwr_dn));

  // any full frame other than a select clears the pending readback
  assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_vld && !is_rbsel) |=> rd_word == '0);

endmodule

// File: rtl/dac_spi_regbank.sv
module dac_spi_regbank
  import dac_spi_pkg::*;
#(
  parameter int NUM_CH     = 16,
  parameter int CH_PER_GRP = 4,
  parameter int DATA_W     = 14,
  parameter int NUM_GOFS   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       cs_n,
  input  logic                       mosi,
  output logic                       miso,
  output logic [NUM_CH*DATA_W-1:0]   ch_code,
  output logic [NUM_GOFS*GOFS_W-1:0] grp_ofs,
  output logic [NUM_CH*GOFS_W-1:0]   ch_grp_ofs,
  output logic                       pwr_dn
);

  logic             rst_s_n;
  logic             sel, sclk_fall, cs_fall, frame_vld;
  frame_t           frame;
  logic [PAY_W-1:0] rd_word;

  dac_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  dac_spi_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .mosi      (mosi),
    .sel       (sel),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall),
    .frame_vld (frame_vld),
    .frame     (frame)
  );

  dac_reg_bank #(
    .NUM_CH   (NUM_CH),
    .DATA_W   (DATA_W),
    .NUM_GOFS (NUM_GOFS)
  ) u_bank (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .frame_vld (frame_vld),
    .frame     (frame),
    .rd_word   (rd_word),
    .ch_code   (ch_code),
    .grp_ofs   (grp_ofs),
    .pwr_dn    (pwr_dn)
  );

  dac_spi_tx u_tx (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .sel       (sel),
    .sclk_fall (sclk_fall),
    .cs_fall   (cs_fall),
    .rd_word   (rd_word),
    .miso      (miso)
  );

  // per-channel view of the shared group offsets, with the last register
  // absorbing every group beyond it
  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_chofs
      localparam int GRP_RAW = gc / CH_PER_GRP;
      localparam int GRP_SEL = (GRP_RAW >= NUM_GOFS) ? NUM_GOFS - 1 : GRP_RAW;
      assign ch_grp_ofs[gc*GOFS_W +: GOFS_W] = grp_ofs[GRP_SEL*GOFS_W +: GOFS_W];
    end
  endgenerate

endmodule

// File: tb/dac_spi_regbank_tb_top.sv
module dac_spi_regbank_tb_top;

  localparam int NCH  = 16;
  localparam int CPG  = 4;
  localparam int DW   = 14;
  localparam int NGO  = 3;
  localparam logic [15:0] MASK = 16'(16'hFFFF << (16 - DW));

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi;
  logic miso, pwr_dn;
  logic [NCH*DW-1:0] ch_code;
  logic [NGO*14-1:0] grp_ofs;
  logic [NCH*14-1:0] ch_grp_ofs;

  always #5 clk = ~clk;

  dac_spi_regbank #(.NUM_CH(NCH), .CH_PER_GRP(CPG), .DATA_W(DW), .NUM_GOFS(NGO)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .ch_code(ch_code), .grp_ofs(grp_ofs), .ch_grp_ofs(ch_grp_ofs), .pwr_dn(pwr_dn)
  );

  logic [15:0] m_dat[NCH];
  logic [15:0] m_ofs[NCH];
  logic [15:0] m_gn[NCH];
  logic [13:0] m_gofs[NGO];
  logic        m_pd;
  logic [15:0] m_rd;
  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rb(input logic [2:0] t, input logic [5:0] a);
    logic [15:0] v = '0;
    int ci = int'(a) - 8;
    if (t <= 3'd3) begin
      if (ci >= 0 && ci < NCH)
        v = (t <= 3'd1) ? m_dat[ci] : (t == 3'd2) ? m_ofs[ci] : m_gn[ci];
    end else if (t == 3'd4) begin
      if (a == 6'd1) v = {15'd0, m_pd};
      else if (a >= 6'd2 && int'(a) < 2 + NGO) v = {2'b00, m_gofs[int'(a) - 2]};
    end
    return v;
  endfunction

  task automatic model_apply(input logic [23:0] w);
    logic [1:0]  md = w[23:22];
    logic [5:0]  a  = w[21:16];
    logic [15:0] p  = w[15:0];
    int ci = int'(a) - 8;
    logic [15:0] nrd = (md == 2'd0 && a == 6'd5) ? exp_rb(p[15:13], p[12:7]) : 16'd0;
    if (md != 2'd0) begin
      if (ci >= 0 && ci < NCH) begin
        if (md == 2'd3) m_dat[ci] = p & MASK;
        else if (md == 2'd2) m_ofs[ci] = p & MASK;
        else m_gn[ci] = p & MASK;
      end
    end else begin
      if (a == 6'd1) m_pd = p[0];
      else if (a >= 6'd2 && int'(a) < 2 + NGO) m_gofs[int'(a) - 2] = p[13:0];
    end
    m_rd = nrd;
  endtask

  task automatic cmp_state(input string tag);
    logic [NCH*DW-1:0] e_code;
    logic [NGO*14-1:0] e_go;
    logic [NCH*14-1:0] e_cgo;
    for (int c = 0; c < NCH; c++) begin
      int g = (c / CPG >= NGO) ? NGO - 1 : c / CPG;
      e_code[c*DW +: DW] = m_dat[c][15 -: DW];
      e_cgo[c*14 +: 14]  = m_gofs[g];
    end
    for (int g = 0; g < NGO; g++) e_go[g*14 +: 14] = m_gofs[g];
    chk({tag, " ch_code"}, 256'(ch_code), 256'(e_code));
    chk({tag, " grp_ofs"}, 256'(grp_ofs), 256'(e_go));
    chk({tag, " ch_grp_ofs"}, 256'(ch_grp_ofs), 256'(e_cgo));
    chk({tag, " pwr_dn"}, 256'(pwr_dn), 256'(m_pd));
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
    got = '0;
    @(negedge clk) cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 24) ? w[23-i] : 1'($urandom);
      repeat (3) @(negedge clk);
      if (i < 24) got[23-i] = miso;
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  // full frame: check returned word, update model, compare outputs
  task automatic frame(input logic [23:0] w, input string tag);
    logic [23:0] got;
    logic [23:0] exp_w = {8'd0, m_rd};
    xfer(w, 24, got);
    chk({tag, " miso"}, 256'(got), 256'(exp_w));
    model_apply(w);
    cmp_state(tag);
  endtask

  function automatic logic [23:0] rbsel(input logic [2:0] t, input logic [5:0] a);
    return {2'd0, 6'd5, t, a, 7'd0};
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] got;
    void'($urandom(32'd4242));
    for (int c = 0; c < NCH; c++) begin m_dat[c] = '0; m_ofs[c] = '0; m_gn[c] = '0; end
    for (int g = 0; g < NGO; g++) m_gofs[g] = '0;
    m_pd = 1'b0; m_rd = '0;
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R12: reset state
    cmp_state("R12");
    chk("R12 miso idle", 256'(miso), 256'(0));
    frame({2'd0, 6'd0, 16'h0000}, "R12 nop");

    // R2/R4: code write, 14-bit justification, readback type 0
    frame({2'd3, 6'd8, 16'hABCD}, "R2 code ch0");
    frame({2'd3, 6'd23, 16'hFFFF}, "R4 code ch15 all ones");
    frame(rbsel(3'd0, 6'd8), "R4 select code ch0");
    frame({2'd0, 6'd0, 16'h0000}, "R4 return ch0 low bits zero");
    frame(rbsel(3'd1, 6'd23), "R8 select type1 ch15");
    frame({2'd0, 6'd0, 16'h0000}, "R8 return type1");

    // R3: offset and gain trims
    frame({2'd2, 6'd13, 16'h1237}, "R3 offset ch5");
    frame({2'd1, 6'd23, 16'hFEDF}, "R3 gain ch15");
    frame(rbsel(3'd2, 6'd13), "R3 select offset");
    frame(rbsel(3'd3, 6'd23), "R3 return offset / select gain");
    frame({2'd0, 6'd0, 16'h0000}, "R3 return gain");

    // R5: power-down set, read, clear
    frame({2'd0, 6'd1, 16'hFFFF}, "R5 pd set");
    frame(rbsel(3'd4, 6'd1), "R5 select ctrl");
    frame({2'd0, 6'd1, 16'h0000}, "R5 return ctrl / pd clear");

    // R6/R7: group offsets and per-channel grouping
    frame({2'd0, 6'd2, 16'hFFFF}, "R6 gofs0 all ones");
    frame({2'd0, 6'd3, 16'h1555}, "R7 gofs1");
    frame({2'd0, 6'd4, 16'h2AAA}, "R7 gofs2 shared by ch8-15");
    frame(rbsel(3'd4, 6'd4), "R6 select gofs2");
    frame({2'd0, 6'd0, 16'h0000}, "R6 return gofs2");

    // R9: pending readback cleared by an intervening frame; bad type/address
    frame(rbsel(3'd0, 6'd8), "R9 select");
    frame({2'd0, 6'd0, 16'h0000}, "R9 nop between");
    frame({2'd0, 6'd0, 16'h0000}, "R9 return zero");
    frame(rbsel(3'd7, 6'd8), "R9 select bad type");
    frame(rbsel(3'd0, 6'd40), "R9 return bad type / select bad addr");
    frame({2'd0, 6'd0, 16'h0000}, "R9 return bad addr");

    // R13: out-of-range channel writes
    frame({2'd3, 6'd24, 16'h5555}, "R13 addr past last channel");
    frame({2'd3, 6'd7, 16'h5555}, "R13 addr below base");
    frame({2'd2, 6'd63, 16'h5555}, "R13 addr 63");

    // R10: short frame discarded, pending readback kept
    frame(rbsel(3'd0, 6'd23), "R10 select before short frame");
    xfer({2'd3, 6'd23, 16'h0000}, 10, got);
    cmp_state("R10 short frame no change");
    frame({2'd0, 6'd0, 16'h0000}, "R10 return still pending");

    // R11: extra bits ignored
    xfer({2'd3, 6'd11, 16'h6789}, 30, got);
    model_apply({2'd3, 6'd11, 16'h6789});
    cmp_state("R11 long frame");

    // R1: random traffic
    for (int n = 0; n < 120; n++) begin
      logic [1:0]  md = 2'($urandom);
      logic [5:0]  a;
      logic [15:0] p = 16'($urandom);
      if (md == 2'd0) begin
        a = 6'($urandom % 7);
        if (a == 6'd5) begin
          p[15:13] = 3'($urandom % 6);
          p[12:7]  = ($urandom % 2 == 0) ? 6'(8 + $urandom % 18) : 6'($urandom % 7);
        end
      end else begin
        a = 6'(8 + $urandom % 18);
      end
      frame({md, a, p}, "R1 random");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule